// File: doc/BRIEF.md
# I2S/TDM Serial Audio Receiver

This block turns a serial audio stream into parallel samples. It takes a bit clock, a frame sync and a serial data line, all asynchronous to the system clock. It rebuilds the slot structure of each frame and emits one 32-bit sign-extended sample per enabled channel. Each sample comes with the index of the slot it came from and a one-cycle valid strobe. The block is a slave only: it never drives the bit clock or the frame sync.

Framing is set by static configuration inputs:
- four alignment standards: Philips, MSB-justified, LSB-justified and PCM short-pulse;
- two-slot stereo or multi-slot TDM;
- 16, 24 or 32 data bits per sample;
- a 16- or 32-bit slot;
- the frame-sync edge that opens a frame;
- a per-slot enable mask.

The receiver copies these inputs while it is disabled and holds the copy for as long as it is enabled. Software can therefore change the inputs at any time without corrupting a stream in flight.

Top module: `i2s_tdm_rx`

## Requirements
- R1: While `enable` is high, the configuration in use stays frozen at the values present on the cycle before `enable` rose. Changes on the configuration inputs during that time have no effect on the samples produced.
- R2: While `enable` is low, no sample is produced and all frame tracking is cleared. After enabling, the first frame-start edge is only recognised once at least one bit-clock rising edge has been observed.
- R3: All frame-sync, data and slot decisions use the levels seen at bit-clock rising edges; data is taken MSB first. Outside PCM, `cfg_rise_start`=0 means a high-to-low frame-sync transition opens a frame, and `cfg_rise_start`=1 means a low-to-high transition opens a frame.
- R4: Standard code 00 (Philips): the first data bit of slot 0 arrives on the bit-clock edge that follows the edge where the frame-sync transition is seen.
- R5: Standard code 01 (MSB-justified): the first data bit of slot 0 arrives on the same bit-clock edge where the frame-sync transition is seen.
- R6: Standard code 10 (LSB-justified): the data bits of each slot occupy the last data-size bits of that slot. The earlier bits of the slot are ignored.
- R7: Standard code 11 (PCM): a low-to-high frame-sync pulse opens the frame whatever `cfg_rise_start` holds, and the first data bit of slot 0 arrives on that same edge.
- R8: The slot is 32 bits unless the data size is 16 bits. With a 16-bit data size, `cfg_slot32`=0 selects a 16-bit slot and `cfg_slot32`=1 selects a 32-bit slot. In left-aligned standards, bits past the data size in a slot are ignored.
- R9: Data-size codes are 00 for 16 bits, 01 for 24 bits and 10 for 32 bits. The received value is sign-extended to 32 bits on `smp_data`.
- R10: With `cfg_tdm`=0 a frame holds 2 slots whatever `cfg_chans` holds. With `cfg_tdm`=1 it holds `cfg_chans` slots with the LSB forced to 0, and a result of 0 counts as 2. Bits beyond the last slot, up to the next frame start, are ignored.
- R11: A sample from slot s is produced only when bit s of `cfg_slot_mask` is 1.
- R12: Data-size code 11 raises `cfg_err`, and no samples are produced while it is in use.
- R13: Each sample is a single-cycle `smp_valid` pulse, with `smp_chan` carrying its slot index (0 for the first slot of the frame). After reset `smp_valid` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Receiver run control; configuration is captured while low |
| cfg_std | input | 2 | Alignment standard: 00 Philips, 01 MSB-justified, 10 LSB-justified, 11 PCM |
| cfg_dsize | input | 2 | Data size: 00 16-bit, 01 24-bit, 10 32-bit, 11 illegal |
| cfg_slot32 | input | 1 | Slot width for 16-bit data: 0 = 16 bits, 1 = 32 bits |
| cfg_tdm | input | 1 | 1 = multi-slot TDM frame, 0 = two-slot stereo |
| cfg_chans | input | 4 | Slots per frame in TDM (LSB ignored) |
| cfg_rise_start | input | 1 | Frame-opening edge: 0 falling, 1 rising (not used by PCM) |
| cfg_slot_mask | input | 32 | Per-slot sample enable, bit s for slot s |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| fsync_in | input | 1 | Frame sync, asynchronous |
| sdata_in | input | 1 | Serial data, asynchronous |
| smp_valid | output | 1 | One-cycle strobe for a new sample |
| smp_data | output | 32 | Sign-extended received sample |
| smp_chan | output | 4 | Slot index of the sample |
| cfg_err | output | 1 | Illegal data size in the active configuration |

## Verification
The bound checker watches on every cycle the properties that hold regardless of stream content:
- the frozen configuration while enabled;
- silence while disabled or with an illegal data size;
- the slot index lying inside the frame and enabled by the mask;
- sign extension of 16-bit samples;
- the single-cycle strobe.

Only the bench scenarios can show that bits land in the right place. These scenarios check, per standard, the one-edge offset of Philips, the end-aligned LSB-justified slot and the polarity-blind PCM pulse. They also check that the stereo-versus-TDM channel count truncates longer frames, and that values and slot indices come out in order.

// File: rtl/i2s_tdm_rx_pkg.sv
package i2s_tdm_rx_pkg;

    localparam int SMP_W  = 32;
    localparam int CHN_W  = 4;
    localparam int MASK_W = 32;
    localparam int POS_W  = 10;
    localparam int BIT_W  = 6;

    typedef enum logic [1:0] {
        FMT_PHILIPS = 2'b00,
        FMT_MSBJ    = 2'b01,
        FMT_LSBJ    = 2'b10,
        FMT_PCM     = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        DW_16  = 2'b00,
        DW_24  = 2'b01,
        DW_32  = 2'b10,
        DW_BAD = 2'b11
    } dsize_e;

    typedef struct packed {
        fmt_e              fmt;
        dsize_e            dsize;
        logic              slot32;
        logic              tdm;
        logic [CHN_W-1:0]  chans;
        logic              rise;
        logic [MASK_W-1:0] mask;
    } rx_cfg_t;

    typedef struct packed {
        logic              sw16;
        logic [POS_W-1:0]  frame_bits;
        logic [BIT_W-1:0]  first_bit;
        logic [BIT_W-1:0]  last_bit;
        logic              delay1;
        logic              start_rise;
        logic              bad;
        dsize_e            dsize;
    } rx_geom_t;

    function automatic rx_geom_t derive_geom(rx_cfg_t c);
        rx_geom_t         g;
        logic [BIT_W-1:0] sw;
        logic [BIT_W-1:0] dw;
        logic [CHN_W-1:0] n;
        g.sw16 = (c.dsize == DW_16) && !c.slot32;
        sw = g.sw16 ? BIT_W'(16) : BIT_W'(32);
        case (c.dsize)
            DW_16:   dw = BIT_W'(16);
            DW_24:   dw = BIT_W'(24);
            default: dw = BIT_W'(32);
        endcase
        n = c.tdm ? {c.chans[CHN_W-1:1], 1'b0} : CHN_W'(2);
        if (n == '0) n = CHN_W'(2);
        g.frame_bits = g.sw16 ? (POS_W'(n) << 4) : (POS_W'(n) << 5);
        g.first_bit  = (c.fmt == FMT_LSBJ) ? (sw - dw) : '0;
        g.last_bit   = g.first_bit + dw - BIT_W'(1);
        g.delay1     = (c.fmt == FMT_PHILIPS);
        g.start_rise = (c.fmt == FMT_PCM) || c.rise;
        g.bad        = (c.dsize == DW_BAD);
        g.dsize      = c.dsize;
        return g;
    endfunction

    function automatic logic [SMP_W-1:0] sign_ext(logic [SMP_W-1:0] v, dsize_e d);
        case (d)
            DW_16:   return {{16{v[15]}}, v[15:0]};
            DW_24:   return {{8{v[23]}}, v[23:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/i2s_tdm_rx_sync.sv
module i2s_tdm_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_a,
    input  logic fsync_a,
    input  logic sdata_a,
    output logic bit_evt,
    output logic fs_s,
    output logic sd_s
);
    localparam int W = 3;

    logic [W-1:0] chain [STAGES];
    logic         bclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            bclk_d <= 1'b0;
        end else begin
            chain[0] <= {bclk_a, fsync_a, sdata_a};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            bclk_d <= chain[STAGES-1][2];
        end
    end

    assign bit_evt = chain[STAGES-1][2] & ~bclk_d;
    assign fs_s    = chain[STAGES-1][1];
    assign sd_s    = chain[STAGES-1][0];

endmodule

// File: rtl/i2s_tdm_rx_cfg.sv
module i2s_tdm_rx_cfg
    import i2s_tdm_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  rx_cfg_t  cfg_in,
    output rx_cfg_t  cfg_q,
    output rx_geom_t geom
);
    always_ff @(posedge clk) begin
        if (rst)          cfg_q <= '0;
        else if (!enable) cfg_q <= cfg_in;
    end

    always_comb geom = derive_geom(cfg_q);

endmodule

// File: rtl/i2s_tdm_rx_deser.sv
module i2s_tdm_rx_deser
    import i2s_tdm_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  rx_geom_t          geom,
    input  logic [MASK_W-1:0] mask,
    input  logic              bit_evt,
    input  logic              fs,
    input  logic              sd,
    output logic              smp_valid,
    output logic [SMP_W-1:0]  smp_data,
    output logic [CHN_W-1:0]  smp_chan
);
    logic             fs_prev, primed, active;
    logic [POS_W-1:0] pos;
    logic [SMP_W-2:0] sh;

    logic             edge_seen, start, lead, take, in_frame, is_data, capture, finish;
    logic [POS_W-1:0] idx;
    logic [4:0]       slot;
    logic [BIT_W-1:0] bpos;
    logic [SMP_W-1:0] word;

    always_comb begin
        edge_seen = geom.start_rise ? (fs & ~fs_prev) : (~fs & fs_prev);
        start     = bit_evt & primed & edge_seen;
        lead      = start & ~geom.delay1;
        idx       = lead ? '0 : pos;
        take      = bit_evt & (lead | active);
        in_frame  = idx < geom.frame_bits;
        slot      = geom.sw16 ? 5'(idx >> 4) : 5'(idx >> 5);
        bpos      = geom.sw16 ? {2'b00, idx[3:0]} : {1'b0, idx[4:0]};
        is_data   = (bpos >= geom.first_bit) && (bpos <= geom.last_bit);
        capture   = take & in_frame & is_data;
        word      = (bpos == geom.first_bit) ? SMP_W'(sd) : {sh, sd};
        finish    = capture & (bpos == geom.last_bit) & mask[slot] & ~geom.bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_data <= '0;
            smp_chan <= '0;
        end else if (finish) begin
            smp_data <= sign_ext(word, geom.dsize);
            smp_chan <= slot[CHN_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            smp_valid <= 1'b0;
            fs_prev   <= 1'b0;
            primed    <= 1'b0;
            active    <= 1'b0;
            pos       <= '0;
            sh        <= '0;
        end else begin
            smp_valid <= finish;
            if (capture) sh <= word[SMP_W-2:0];
            if (bit_evt) begin
                fs_prev <= fs;
                primed  <= 1'b1;
                if (start) begin
                    active <= 1'b1;
                    pos    <= geom.delay1 ? POS_W'(0) : POS_W'(1);
                end else if (pos != '1) begin
                    pos <= pos + POS_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/i2s_tdm_rx.sv
module i2s_tdm_rx
    import i2s_tdm_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [1:0]        cfg_std,
    input  logic [1:0]        cfg_dsize,
    input  logic              cfg_slot32,
    input  logic              cfg_tdm,
    input  logic [CHN_W-1:0]  cfg_chans,
    input  logic              cfg_rise_start,
    input  logic [MASK_W-1:0] cfg_slot_mask,
    input  logic              bclk_in,
    input  logic              fsync_in,
    input  logic              sdata_in,
    output logic              smp_valid,
    output logic [SMP_W-1:0]  smp_data,
    output logic [CHN_W-1:0]  smp_chan,
    output logic              cfg_err
);
    rx_cfg_t  cfg_in, cfg_q;
    rx_geom_t geom;
    logic     bit_evt, fs_s, sd_s;

    always_comb begin
        cfg_in.fmt    = fmt_e'(cfg_std);
        cfg_in.dsize  = dsize_e'(cfg_dsize);
        cfg_in.slot32 = cfg_slot32;
        cfg_in.tdm    = cfg_tdm;
        cfg_in.chans  = cfg_chans;
        cfg_in.rise   = cfg_rise_start;
        cfg_in.mask   = cfg_slot_mask;
    end

    i2s_tdm_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .bclk_a(bclk_in), .fsync_a(fsync_in), .sdata_a(sdata_in),
        .bit_evt(bit_evt), .fs_s(fs_s), .sd_s(sd_s)
    );

    i2s_tdm_rx_cfg u_cfg (
        .clk(clk), .rst(rst), .enable(enable),
        .cfg_in(cfg_in), .cfg_q(cfg_q), .geom(geom)
    );

    i2s_tdm_rx_deser u_deser (
        .clk(clk), .rst(rst), .enable(enable),
        .geom(geom), .mask(cfg_q.mask),
        .bit_evt(bit_evt), .fs(fs_s), .sd(sd_s),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan)
    );

    assign cfg_err = geom.bad;

endmodule

// File: rtl/i2s_tdm_rx_chk.sv
module i2s_tdm_rx_chk
    import i2s_tdm_rx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             smp_valid,
    input logic [SMP_W-1:0] smp_data,
    input logic [CHN_W-1:0] smp_chan,
    input logic             cfg_err,
    input rx_cfg_t          cfg_q
);
    logic [CHN_W-1:0] slots_allowed;
    always_comb begin
        slots_allowed = cfg_q.tdm ? {cfg_q.chans[CHN_W-1:1], 1'b0} : CHN_W'(2);
        if (slots_allowed == '0) slots_allowed = CHN_W'(2);
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        enable |=> (!enable || $stable(cfg_q)));                            // R1
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !smp_valid);                                            // R2
    AST_BAD_SILENT: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !smp_valid);                                            // R12
    AST_MASKED_SLOT: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> cfg_q.mask[smp_chan]);                                // R11
    AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> (smp_chan < slots_allowed));                          // R10
    AST_SEXT_16: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && cfg_q.dsize == DW_16) |->
        ($countones(smp_data[31:15]) == 0 || $countones(smp_data[31:15]) == 17)); // R9
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid);                                          // R13

endmodule

bind i2s_tdm_rx i2s_tdm_rx_chk i_chk (
    .clk(clk), .rst(rst), .enable(enable),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan),
    .cfg_err(cfg_err), .cfg_q(cfg_q)
);

// File: tb/test_i2s_tdm_rx.sv
module test_i2s_tdm_rx;
    localparam int CLK_PERIOD = 10;
    localparam int HB         = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [1:0]  cfg_std = '0, cfg_dsize = '0;
    logic        cfg_slot32 = 1'b0, cfg_tdm = 1'b0, cfg_rise_start = 1'b0;
    logic [3:0]  cfg_chans = 4'd2;
    logic [31:0] cfg_slot_mask = '1;
    logic        bclk_in = 1'b0, fsync_in = 1'b0, sdata_in = 1'b0;
    logic        smp_valid, cfg_err;
    logic [31:0] smp_data;
    logic [3:0]  smp_chan;

    int n_chk = 0, n_fail = 0;
    logic [31:0] got_d[$], exp_d[$];
    logic [3:0]  got_c[$], exp_c[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2s_tdm_rx i_i2s_tdm_rx (
        .clk(clk), .rst(rst), .enable(enable),
        .cfg_std(cfg_std), .cfg_dsize(cfg_dsize), .cfg_slot32(cfg_slot32),
        .cfg_tdm(cfg_tdm), .cfg_chans(cfg_chans), .cfg_rise_start(cfg_rise_start),
        .cfg_slot_mask(cfg_slot_mask),
        .bclk_in(bclk_in), .fsync_in(fsync_in), .sdata_in(sdata_in),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan),
        .cfg_err(cfg_err)
    );

    always @(negedge clk) begin
        if (!rst && smp_valid) begin
            got_d.push_back(smp_data);
            got_c.push_back(smp_chan);
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] val_of(int f, int s, int dw);
        logic [31:0] v;
        v = (32'h9E37_79B9 * 32'(f * 16 + s + 3)) ^ 32'h5A5A_0F0F;
        if (dw < 32) v = v & ((32'h1 << dw) - 32'h1);
        return v;
    endfunction

    function automatic logic [31:0] sext_ref(logic [31:0] v, int dw);
        if (dw == 16) return {{16{v[15]}}, v[15:0]};
        if (dw == 24) return {{8{v[23]}}, v[23:0]};
        return v;
    endfunction

    task automatic send_bit(input logic f, input logic d);
        bclk_in = 1'b0; fsync_in = f; sdata_in = d;
        repeat (HB) @(negedge clk);
        bclk_in = 1'b1;
        repeat (HB) @(negedge clk);
    endtask

    task automatic configure(input int std, input int dsz, input logic s32, input logic tdm,
                             input int ch, input logic rise, input logic [31:0] mask);
        @(negedge clk);
        enable = 1'b0;
        cfg_std = 2'(std); cfg_dsize = 2'(dsz); cfg_slot32 = s32; cfg_tdm = tdm;
        cfg_chans = 4'(ch); cfg_rise_start = rise; cfg_slot_mask = mask;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        repeat (2) @(negedge clk);
        got_d.delete(); got_c.delete(); exp_d.delete(); exp_c.delete();
    endtask

    // Stream built from the framing rules; expected samples from mask/count.
    task automatic stream(input int fmt, input int dw, input int sw, input int nsend,
                          input int nexp, input logic rise, input logic [31:0] mask,
                          input int nframes, input logic produce);
        logic l1, idle;
        int   fbits, total, off;
        l1    = (fmt == 3) ? 1'b1 : rise;
        idle  = (fmt == 3) ? 1'b0 : ~l1;
        fbits = nsend * sw;
        total = nframes * fbits;
        off   = (fmt == 2) ? sw - dw : 0;
        for (int i = 0; i < 6; i++)
            send_bit((fmt == 0 && i == 5) ? l1 : idle, 1'b0);
        for (int p = 0; p < total; p++) begin
            int f, t, s, b, tf;
            logic d, fl;
            f = p / fbits; t = p % fbits; s = t / sw; b = t % sw;
            d = 1'b0;
            if (b >= off && b < off + dw) d = val_of(f, s, dw)[dw - 1 - (b - off)];
            tf = (fmt == 0) ? p + 1 : p;
            if (tf < total) begin
                int tt;
                tt = tf % fbits;
                fl = (fmt == 3) ? (tt == 0) : ((tt < fbits / 2) ? l1 : ~l1);
            end else begin
                fl = idle;
            end
            send_bit(fl, d);
        end
        for (int i = 0; i < 4; i++) send_bit(idle, 1'b0);
        repeat (10) @(negedge clk);
        if (produce)
            for (int f = 0; f < nframes; f++)
                for (int s = 0; s < nexp; s++)
                    if (mask[s]) begin
                        exp_d.push_back(sext_ref(val_of(f, s, dw), dw));
                        exp_c.push_back(4'(s));
                    end
    endtask

    task automatic compare(input string req);
        check(got_d.size() == exp_d.size(), req, "sample count",
              32'(got_d.size()), 32'(exp_d.size()));
        if (got_d.size() == exp_d.size())
            for (int i = 0; i < exp_d.size(); i++) begin
                check(got_d[i] == exp_d[i], req, "sample data", got_d[i], exp_d[i]);
                check(got_c[i] == exp_c[i], req, "sample slot", 32'(got_c[i]), 32'(exp_c[i]));
            end
    endtask

    task automatic t_reset;
        check(smp_valid == 1'b0, "R13", "valid after reset", 32'(smp_valid), 0);
        check(cfg_err == 1'b0, "R13", "err after reset", 32'(cfg_err), 0);
    endtask

    task automatic t_philips;   // R4, R3 falling start, 16-bit slots (R8)
        configure(0, 0, 1'b0, 1'b0, 2, 1'b0, 32'h3);
        stream(0, 16, 16, 2, 2, 1'b0, 32'h3, 3, 1'b1);
        compare("R4");
    endtask

    task automatic t_msbj;      // R5, R3 rising start, 24 bits forced into 32-bit slot (R8, R9)
        configure(1, 1, 1'b0, 1'b0, 2, 1'b1, 32'h3);
        stream(1, 24, 32, 2, 2, 1'b1, 32'h3, 2, 1'b1);
        compare("R5");
    endtask

    task automatic t_lsbj;      // R6: 16 bits at the end of a 32-bit slot
        configure(2, 0, 1'b1, 1'b0, 2, 1'b1, 32'h3);
        stream(2, 16, 32, 2, 2, 1'b1, 32'h3, 2, 1'b1);
        compare("R6");
    endtask

    task automatic t_pcm_tdm;   // R7 polarity bit ignored, R11 mask 0xA5
        configure(3, 2, 1'b0, 1'b1, 8, 1'b0, 32'h0000_00A5);
        stream(3, 32, 32, 8, 8, 1'b0, 32'h0000_00A5, 2, 1'b1);
        compare("R7");
    endtask

    task automatic t_chan_count;    // R10
        configure(1, 0, 1'b0, 1'b0, 8, 1'b1, 32'hFFFF_FFFF);
        stream(1, 16, 16, 4, 2, 1'b1, 32'hFFFF_FFFF, 2, 1'b1);
        compare("R10");
        configure(1, 0, 1'b0, 1'b1, 5, 1'b1, 32'hFFFF_FFFF);
        stream(1, 16, 16, 6, 4, 1'b1, 32'hFFFF_FFFF, 2, 1'b1);
        compare("R10");
    endtask

    task automatic t_bad_size;      // R12
        configure(1, 3, 1'b0, 1'b0, 2, 1'b1, 32'h3);
        check(cfg_err == 1'b1, "R12", "err flag", 32'(cfg_err), 1);
        stream(1, 32, 32, 2, 2, 1'b1, 32'h3, 2, 1'b0);
        compare("R12");
    endtask

    task automatic t_disabled;      // R2
        configure(1, 0, 1'b0, 1'b0, 2, 1'b1, 32'h3);
        @(negedge clk) enable = 1'b0;
        stream(1, 16, 16, 2, 2, 1'b1, 32'h3, 2, 1'b0);
        compare("R2");
    endtask

    task automatic t_frozen;        // R1
        configure(0, 0, 1'b0, 1'b0, 2, 1'b0, 32'h3);
        cfg_std = 2'b01; cfg_dsize = 2'b10; cfg_rise_start = 1'b1; cfg_slot_mask = '0;
        stream(0, 16, 16, 2, 2, 1'b0, 32'h3, 2, 1'b1);
        compare("R1");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_philips();
        t_msbj();
        t_lsbj();
        t_pcm_tdm();
        t_chan_count();
        t_bad_size();
        t_disabled();
        t_frozen();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule